// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Snapshot

This block is the counting core of a real-time clock. A 1 Hz tick advances a set of BCD counters: seconds, minutes, hours, day of week, date, month, two-digit year, and a single century bit that toggles each time the year wraps. Month lengths of 30 and 31 days are handled, and February is given 29 days in years that divide by four.

Software never touches the live counters directly. It works through a bank of eight holding registers on a small read/write port. A rising edge on the snapshot control copies the live time into the bank, and the bank then stays frozen for as long as that control is held high. To set the clock, software raises the set control, writes the bank, and drops the control. The falling edge loads the bank into the counters.

While the set control is high the counters stand still. Ticks that arrive in that window are counted, and after the load they are replayed at one per clock cycle, so no second is lost. A snapshot request that arrives while the sequencer is locked, loading or catching up is held back until the counters are current again. Values written to the bank are never range-checked.

Top module: `rtc_snapshot_core`

The sequencer has four named states:
- RUN: ticks step the counters and snapshots are served.
- LOCKED: entered from RUN or CATCHUP when the set control goes high. Counters are frozen and ticks are only counted.
- LOAD: entered from LOCKED when the set control falls. The bank is copied into the counters.
- CATCHUP: entered from LOAD when ticks are owed. It steps once per cycle and returns to RUN when nothing is owed, or goes back to LOCKED if the set control rises again.

## Requirements
- R1: After reset, all eight bank registers and the live counters read 00 for seconds, minutes, hours, year and the century bit, and 01 for day of week, date and month.
- R2: Seconds and minutes count in BCD from 00 to 59. On a tick at 59 the field returns to 00 and carries into the next field.
- R3: Hours count 00 to 23 and wrap to 00. That wrap advances the day of week (7 is followed by 1) and advances the date.
- R4: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12. The wrap advances the month.
- R5: In month 02 the date wraps after 29 when the BCD year is divisible by four (00 counts as divisible), and after 28 otherwise.
- R6: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and toggles the century bit.
- R7: A rising edge of `snap_rd` copies the live time into the bank. While `snap_rd` stays high, the bank does not change and register writes are ignored.
- R8: Bank addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 century (bit 0). Read data is zero-extended, and written bits above each field's width are dropped.
- R9: While `snap_wr` is high the live counters hold still and incoming ticks are counted. The falling edge of `snap_wr` loads the bank into the counters, and the counted ticks are then applied one per cycle on top of the loaded time.
- R10: Out-of-range BCD values are not corrected. A units digit of 9 or more becomes 0 and the tens digit increments. A field carries into the next field only when it equals its wrap value.
- R11: A snapshot edge seen while the sequencer is not in RUN is deferred. It is served once the counters are back in RUN, so it reflects the replayed ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| snap_rd | input | 1 | Snapshot control; its rising edge captures the live time |
| snap_wr | input | 1 | Set control; high locks the counters, falling edge loads the bank |
| reg_addr | input | 3 | Bank register address |
| reg_wr_en | input | 1 | Write strobe for the bank |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed bank register |

## Verification
The assertions check four things on every cycle: the counters are frozen while locked, seconds and hours wrap correctly, the century bit moves only on a year wrap or a load, and the bank is stable during a snapshot. They also check that owed ticks are never dropped except by a step, and that a load and a step never coincide.

Some behaviour only the bench scenarios can show. These are the month-length and leap-year table swept across all twelve months and several years, the day-of-week cycle, and the exact time after a lock with ticks replayed. The bench also covers deferred snapshot content and the drift of invalid BCD values.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

    localparam int NREG   = 8;
    localparam int REG_AW = 3;

    localparam int ADDR_SEC  = 0;
    localparam int ADDR_MIN  = 1;
    localparam int ADDR_HOUR = 2;
    localparam int ADDR_DOW  = 3;
    localparam int ADDR_DATE = 4;
    localparam int ADDR_MON  = 5;
    localparam int ADDR_YEAR = 6;
    localparam int ADDR_CENT = 7;

    typedef struct packed {
        logic       cent;
        logic [7:0] year;
        logic [4:0] mon;
        logic [5:0] date;
        logic [2:0] dow;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } rtc_time_t;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_LOCKED,
        ST_LOAD,
        ST_CATCHUP
    } rtc_state_e;

    localparam rtc_time_t RESET_TIME = '{
        cent: 1'b0, year: 8'h00, mon: 5'h01, date: 6'h01,
        dow: 3'd1, hour: 6'h00, min: 7'h00, sec: 7'h00
    };

    function automatic logic is_leap_bcd(input logic [7:0] y);
        logic unit_ok_even;
        logic unit_ok_odd;
        unit_ok_even = (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
        unit_ok_odd  = (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
        return y[4] ? unit_ok_odd : unit_ok_even;
    endfunction

    function automatic logic [5:0] month_last_bcd(input logic [4:0] m,
                                                  input logic [7:0] y);
        logic [5:0] last;
        unique case (m)
            5'h04, 5'h06, 5'h09, 5'h11: last = 6'h30;
            5'h02:                      last = is_leap_bcd(y) ? 6'h29 : 6'h28;
            default:                    last = 6'h31;
        endcase
        return last;
    endfunction

    function automatic logic [7:0] field_mask(input int idx);
        logic [7:0] m;
        unique case (idx)
            ADDR_SEC, ADDR_MIN: m = 8'h7F;
            ADDR_HOUR, ADDR_DATE: m = 8'h3F;
            ADDR_DOW:  m = 8'h07;
            ADDR_MON:  m = 8'h1F;
            ADDR_YEAR: m = 8'hFF;
            default:   m = 8'h01;
        endcase
        return m;
    endfunction

    function automatic logic [7:0] reset_byte(input int idx);
        logic [7:0] v;
        unique case (idx)
            ADDR_DOW, ADDR_DATE, ADDR_MON: v = 8'h01;
            default:                       v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rtc_bcd_inc.sv
module rtc_bcd_inc #(
    parameter int W = 7
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] inc
);
    localparam int HW = W - 4;

    logic [HW-1:0] hi;
    logic [3:0]    lo;

    assign hi = val[W-1:4];
    assign lo = val[3:0];

    always_comb begin
        if (lo >= 4'd9) begin
            inc = {hi + HW'(1), 4'h0};
        end else begin
            inc = {hi, lo + 4'd1};
        end
    end
endmodule

// File: rtl/rtc_calendar_next.sv
module rtc_calendar_next
    import rtc_snap_pkg::*;
(
    input  rtc_time_t cur,
    output rtc_time_t nxt
);
    logic [6:0] sec_up;
    logic [6:0] min_up;
    logic [5:0] hour_up;
    logic [5:0] date_up;
    logic [4:0] mon_up;
    logic [7:0] year_up;
    logic [5:0] last_day;

    logic c_sec, c_min, c_hour, c_date, c_mon, c_year;

    rtc_bcd_inc #(.W(7)) u_inc_sec  (.val(cur.sec),  .inc(sec_up));
    rtc_bcd_inc #(.W(7)) u_inc_min  (.val(cur.min),  .inc(min_up));
    rtc_bcd_inc #(.W(6)) u_inc_hour (.val(cur.hour), .inc(hour_up));
    rtc_bcd_inc #(.W(6)) u_inc_date (.val(cur.date), .inc(date_up));
    rtc_bcd_inc #(.W(5)) u_inc_mon  (.val(cur.mon),  .inc(mon_up));
    rtc_bcd_inc #(.W(8)) u_inc_year (.val(cur.year), .inc(year_up));

    assign last_day = month_last_bcd(cur.mon, cur.year);

    // carry chain: each field wraps only on an exact match with its limit
    assign c_sec  = (cur.sec == 7'h59);
    assign c_min  = c_sec  && (cur.min == 7'h59);
    assign c_hour = c_min  && (cur.hour == 6'h23);
    assign c_date = c_hour && (cur.date == last_day);
    assign c_mon  = c_date && (cur.mon == 5'h12);
    assign c_year = c_mon  && (cur.year == 8'h99);

    always_comb begin
        nxt      = cur;
        nxt.sec  = c_sec ? 7'h00 : sec_up;
        if (c_sec) begin
            nxt.min = c_min ? 7'h00 : min_up;
        end
        if (c_min) begin
            nxt.hour = c_hour ? 6'h00 : hour_up;
        end
        if (c_hour) begin
            nxt.dow  = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
            nxt.date = c_date ? 6'h01 : date_up;
        end
        if (c_date) begin
            nxt.mon = c_mon ? 5'h01 : mon_up;
        end
        if (c_mon) begin
            nxt.year = c_year ? 8'h00 : year_up;
        end
        if (c_year) begin
            nxt.cent = ~cur.cent;
        end
    end
endmodule

// File: rtl/rtc_user_bank.sv
module rtc_user_bank
    import rtc_snap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              freeze,
    input  logic              cap,
    input  rtc_time_t         live,
    output logic [7:0]        rdata,
    output rtc_time_t         held
);
    logic [7:0] live_b [NREG];
    logic [7:0] hold_r [NREG];

    always_comb begin
        live_b[ADDR_SEC]  = {1'b0, live.sec};
        live_b[ADDR_MIN]  = {1'b0, live.min};
        live_b[ADDR_HOUR] = {2'b00, live.hour};
        live_b[ADDR_DOW]  = {5'b00000, live.dow};
        live_b[ADDR_DATE] = {2'b00, live.date};
        live_b[ADDR_MON]  = {3'b000, live.mon};
        live_b[ADDR_YEAR] = live.year;
        live_b[ADDR_CENT] = {7'b0000000, live.cent};
    end

    for (genvar i = 0; i < NREG; i++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_r[i] <= reset_byte(i);
            end else if (cap) begin
                hold_r[i] <= live_b[i];
            end else if (wr_en && !freeze && (addr == REG_AW'(i))) begin
                hold_r[i] <= wdata & field_mask(i);
            end
        end
    end

    assign rdata = hold_r[addr];

    always_comb begin
        held.sec  = hold_r[ADDR_SEC][6:0];
        held.min  = hold_r[ADDR_MIN][6:0];
        held.hour = hold_r[ADDR_HOUR][5:0];
        held.dow  = hold_r[ADDR_DOW][2:0];
        held.date = hold_r[ADDR_DATE][5:0];
        held.mon  = hold_r[ADDR_MON][4:0];
        held.year = hold_r[ADDR_YEAR];
        held.cent = hold_r[ADDR_CENT][0];
    end
endmodule

// File: rtl/rtc_seq_ctrl.sv
module rtc_seq_ctrl
    import rtc_snap_pkg::*;
#(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              set_req,
    input  logic              snap_req,
    output logic              step,
    output logic              load,
    output logic              cap,
    output logic              locked,
    output logic [PEND_W-1:0] pend
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    rtc_state_e        state_q, state_d;
    logic [PEND_W-1:0] pend_d;
    logic              snap_q;
    logic              cap_wait_q, cap_wait_d;
    logic              snap_rise;
    logic [PEND_W-1:0] pend_plus;
    logic [PEND_W-1:0] pend_drain;

    assign snap_rise  = snap_req && !snap_q;
    assign pend_plus  = (tick && pend != PEND_MAX) ? pend + PEND_W'(1) : pend;
    assign pend_drain = tick ? pend : pend - PEND_W'(1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_RUN;
            pend       <= '0;
            snap_q     <= 1'b0;
            cap_wait_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            pend       <= pend_d;
            snap_q     <= snap_req;
            cap_wait_q <= cap_wait_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        pend_d     = pend;
        step       = 1'b0;
        load       = 1'b0;
        cap        = 1'b0;
        locked     = 1'b0;
        cap_wait_d = cap_wait_q || snap_rise;
        unique case (state_q)
            ST_RUN: begin
                if (set_req) begin
                    state_d = ST_LOCKED;
                    pend_d  = pend_plus;
                end else begin
                    step = tick;
                    if (cap_wait_q || snap_rise) begin
                        cap        = 1'b1;
                        cap_wait_d = 1'b0;
                    end
                end
            end
            ST_LOCKED: begin
                locked = 1'b1;
                pend_d = pend_plus;
                if (!set_req) begin
                    state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                load   = 1'b1;
                pend_d = pend_plus;
                if (set_req) begin
                    state_d = ST_LOCKED;
                end else if (pend_plus != '0) begin
                    state_d = ST_CATCHUP;
                end else begin
                    state_d = ST_RUN;
                end
            end
            ST_CATCHUP: begin
                if (set_req) begin
                    state_d = ST_LOCKED;
                    pend_d  = pend_plus;
                end else begin
                    step   = 1'b1;
                    pend_d = pend_drain;
                    if (pend_drain == '0) begin
                        state_d = ST_RUN;
                    end
                end
            end
            default: state_d = ST_RUN;
        endcase
    end
endmodule

// File: rtl/rtc_snapshot_core.sv
module rtc_snapshot_core
    import rtc_snap_pkg::*;
#(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              snap_rd,
    input  logic              snap_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata
);
    rtc_time_t         time_q;
    rtc_time_t         time_nx;
    rtc_time_t         held_time;
    logic              core_step;
    logic              core_load;
    logic              core_cap;
    logic              core_locked;
    logic [PEND_W-1:0] pend_cnt;

    rtc_seq_ctrl #(.PEND_W(PEND_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .set_req  (snap_wr),
        .snap_req (snap_rd),
        .step     (core_step),
        .load     (core_load),
        .cap      (core_cap),
        .locked   (core_locked),
        .pend     (pend_cnt)
    );

    rtc_calendar_next u_next (
        .cur (time_q),
        .nxt (time_nx)
    );

    rtc_user_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .freeze (snap_rd),
        .cap    (core_cap),
        .live   (time_q),
        .rdata  (reg_rdata),
        .held   (held_time)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= RESET_TIME;
        end else if (core_load) begin
            time_q <= held_time;
        end else if (core_step) begin
            time_q <= time_nx;
        end
    end
endmodule

// File: rtl/rtc_snapshot_core_chk.sv
module rtc_snapshot_core_chk
    import rtc_snap_pkg::*;
#(
    parameter int PEND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input rtc_time_t         time_q,
    input logic              step,
    input logic              load,
    input logic              cap,
    input logic              locked,
    input logic [PEND_W-1:0] pend,
    input logic              snap_rd,
    input rtc_time_t         held
);
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(time_q)); // R9

    AST_LOAD_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load, step})); // R9

    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> pend >= $past(pend)); // R9

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && time_q.sec == 7'h59) |=> time_q.sec == 7'h00); // R2

    AST_NO_FALSE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && time_q.sec != 7'h59) |=> $stable(time_q.min)); // R10

    AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && time_q.sec == 7'h59 && time_q.min == 7'h59 && time_q.hour == 6'h23)
        |=> (time_q.hour == 6'h00) && !$stable(time_q.dow)); // R3

    AST_CENT_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(step && time_q.year == 8'h99)) |=> $stable(time_q.cent)); // R6

    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_rd && !cap) |=> $stable(held)); // R7
endmodule

bind rtc_snapshot_core rtc_snapshot_core_chk #(.PEND_W(PEND_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .time_q  (time_q),
    .step    (core_step),
    .load    (core_load),
    .cap     (core_cap),
    .locked  (core_locked),
    .pend    (pend_cnt),
    .snap_rd (snap_rd),
    .held    (held_time)
);

// File: tb/rtc_snapshot_core_test.sv
module rtc_snapshot_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       snap_rd = 1'b0;
    logic       snap_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rtc_snapshot_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick_1hz),
        .snap_rd   (snap_rd),
        .snap_wr   (snap_wr),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [7:0] bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int days_in(input int m, input int y);
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        return 31;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 d = reg_rdata;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = 3'(a);
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic write_bank(input int s, input int mi, input int h, input int dw,
                              input int d, input int mo, input int y, input int c);
        wr(0, bcd(s));  wr(1, bcd(mi)); wr(2, bcd(h));  wr(3, bcd(dw));
        wr(4, bcd(d));  wr(5, bcd(mo)); wr(6, bcd(y));  wr(7, 8'(c));
    endtask

    task automatic set_time(input int s, input int mi, input int h, input int dw,
                            input int d, input int mo, input int y, input int c);
        @(negedge clk);
        snap_wr = 1'b1;
        write_bank(s, mi, h, dw, d, mo, y, c);
        @(negedge clk);
        snap_wr = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic snap_on();
        @(negedge clk);
        snap_rd = 1'b1;
        @(negedge clk);
    endtask

    task automatic snap_off();
        @(negedge clk);
        snap_rd = 1'b0;
    endtask

    logic [7:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values in the bank and in the live counters
        rd(0, v); chk("R1 sec", v, 8'h00);
        rd(3, v); chk("R1 dow", v, 8'h01);
        rd(4, v); chk("R1 date", v, 8'h01);
        rd(5, v); chk("R1 mon", v, 8'h01);
        rd(7, v); chk("R1 cent", v, 8'h00);
        snap_on();
        rd(2, v); chk("R1 live hour", v, 8'h00);
        rd(5, v); chk("R1 live mon", v, 8'h01);
        snap_off();

        // R8 field widths mask written data
        wr(0, 8'hFF); rd(0, v); chk("R8 sec mask", v, 8'h7F);
        wr(3, 8'hFF); rd(3, v); chk("R8 dow mask", v, 8'h07);
        wr(7, 8'hFF); rd(7, v); chk("R8 cent mask", v, 8'h01);

        // R2 long second/minute/hour sweep
        set_time(0, 0, 0, 1, 1, 1, 0, 0);
        for (int i = 0; i < 59; i++) tick();
        snap_on();
        rd(0, v); chk("R2 sec 59", v, 8'h59);
        rd(1, v); chk("R2 min 00", v, 8'h00);
        snap_off();
        tick();
        snap_on();
        rd(0, v); chk("R2 sec wrap", v, 8'h00);
        rd(1, v); chk("R2 min carry", v, 8'h01);
        snap_off();
        for (int i = 0; i < 3665; i++) tick();
        snap_on();
        rd(0, v); chk("R2 sec long", v, bcd(5));
        rd(1, v); chk("R2 min long", v, bcd(2));
        rd(2, v); chk("R2 hour long", v, bcd(1));
        snap_off();

        // R3 day-of-week cycle across midnight
        for (int d = 1; d <= 7; d++) begin
            set_time(59, 59, 23, d, 10, 3, 5, 0);
            tick();
            snap_on();
            rd(2, v); chk("R3 hour wrap", v, 8'h00);
            rd(3, v); chk("R3 dow next", v, bcd(d % 7 + 1));
            rd(4, v); chk("R3 date next", v, bcd(11));
            snap_off();
        end

        // R4 R5 R6 month-end sweep over months and years
        for (int m = 1; m <= 12; m++) begin
            for (int k = 0; k < 6; k++) begin
                int y, dim, ny, nc;
                y   = (k == 0) ? 0 : (k == 1) ? 23 : (k == 2) ? 24 :
                      (k == 3) ? 98 : (k == 4) ? 99 : 1;
                dim = days_in(m, y);
                set_time(59, 59, 23, 2, dim - 1, m, y, 1);
                tick();
                snap_on();
                rd(4, v); chk((m == 2) ? "R5 date before end" : "R4 date before end", v, bcd(dim));
                rd(5, v); chk("R4 month held", v, bcd(m));
                snap_off();
                set_time(59, 59, 23, 2, dim, m, y, 1);
                tick();
                ny = (m == 12) ? (y + 1) % 100 : y;
                nc = (m == 12 && y == 99) ? 0 : 1;
                snap_on();
                rd(4, v); chk((m == 2) ? "R5 date wrap" : "R4 date wrap", v, 8'h01);
                rd(5, v); chk("R6 month next", v, bcd(m % 12 + 1));
                rd(6, v); chk("R6 year", v, bcd(ny));
                rd(7, v); chk("R6 century", v, 8'(nc));
                rd(0, v); chk("R2 sec at month end", v, 8'h00);
                snap_off();
            end
        end

        // R7 bank frozen while snapshot held
        set_time(12, 34, 5, 3, 6, 7, 8, 0);
        snap_on();
        wr(0, 8'h33);
        rd(0, v); chk("R7 write ignored", v, 8'h12);
        tick();
        rd(0, v); chk("R7 snapshot stable", v, 8'h12);
        snap_off();
        snap_on();
        rd(0, v); chk("R7 new snapshot", v, 8'h13);
        snap_off();

        // R9 ticks during lock are replayed
        @(negedge clk); snap_wr = 1'b1;
        tick(); tick(); tick();
        write_bank(30, 20, 10, 4, 15, 6, 40, 0);
        @(negedge clk); snap_wr = 1'b0;
        repeat (10) @(negedge clk);
        snap_on();
        rd(0, v); chk("R9 replayed sec", v, 8'h33);
        rd(1, v); chk("R9 loaded min", v, 8'h20);
        rd(2, v); chk("R9 loaded hour", v, 8'h10);
        snap_off();

        // R10 invalid BCD drifts without correction or false carry
        set_time(0, 7, 2, 1, 1, 1, 0, 0);
        wr(0, 8'h5A);
        @(negedge clk); snap_wr = 1'b1;
        @(negedge clk); snap_wr = 1'b0;
        repeat (4) @(negedge clk);
        tick();
        snap_on();
        rd(0, v); chk("R10 sec 5A->60", v, 8'h60);
        rd(1, v); chk("R10 no carry", v, 8'h07);
        snap_off();
        tick();
        snap_on();
        rd(0, v); chk("R10 sec 60->61", v, 8'h61);
        snap_off();

        // R11 snapshot during lock deferred past replay
        @(negedge clk); snap_wr = 1'b1;
        tick(); tick();
        write_bank(0, 15, 8, 1, 1, 1, 0, 0);
        @(negedge clk); snap_rd = 1'b1;
        tick();
        @(negedge clk); snap_wr = 1'b0;
        repeat (10) @(negedge clk);
        rd(0, v); chk("R11 deferred sec", v, 8'h03);
        rd(1, v); chk("R11 deferred min", v, 8'h15);
        rd(2, v); chk("R11 deferred hour", v, 8'h08);
        snap_off();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule